// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

The block connects two 18-bit ports, A and B, with one storage path per direction. Each path has three controls: a latch enable, a direction clock and an output enable. With the latch enable high the path is transparent, and the far port shows the near input in the same cycle. With the latch enable low the path holds its stored word. While the latch enable is low, a rising transition of the direction clock loads a new word.

The core is fully synchronous to a system clock `clk_i`. The direction clocks are sampled as ordinary inputs, and a rise is seen when the current sample is high and the previous one was low. Each port has a data output and a drive flag, which a pad wrapper turns into a tri-state driver. A disabled port outputs all zeros. The two directions never interact, so both ports may drive at the same time.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: Each direction carries WIDTH (default 18) independent bits. The controls of one direction never change the output of the other direction.
- R2: When `le_ab_i` is 1 and the B port is enabled, `b_o` equals `a_i` in the same cycle, with no clock delay.
- R3: On the first cycle after `le_ab_i` falls, with no direction-clock rise, `b_o` shows the `a_i` value sampled at the last `clk_i` edge while `le_ab_i` was still 1.
- R4: When `le_ab_i` is 0 and `clk_ab_i` stays at a constant level, the stored word does not change, whatever `a_i` does.
- R5: When `le_ab_i` is 0 and `clk_ab_i` is sampled 1 at a `clk_i` edge after being sampled 0 at the edge before, `a_i` from that edge is stored. `b_o` shows it right after that edge.
- R6: A rise of `clk_ab_i` while `le_ab_i` is 1 does not disturb transparent operation. `b_o` still equals `a_i`.
- R7: `oe_ab_i` is active high. When it is 0, `b_oe_o` is 0 and `b_o` is all zeros. When it is 1, `b_oe_o` is 1.
- R8: The B-to-A direction behaves the same way under `le_ba_i` and `clk_ba_i`, but its enable `oe_ba_ni` is active low. `a_oe_o` equals the inverse of `oe_ba_ni`, and a disabled A port outputs zeros.
- R9: While `rst_ni` is 0, both stored words are zero and both clock histories read low. An enabled port with its latch enable low outputs zero.
- R10: With both ports enabled, each port drives its own direction's value. No arbitration takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; samples the controls and updates storage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | Data arriving on port A |
| a_o | output | 18 | Data driven onto port A (B-to-A path) |
| a_oe_o | output | 1 | Drive flag for port A |
| b_i | input | 18 | Data arriving on port B |
| b_o | output | 18 | Data driven onto port B (A-to-B path) |
| b_oe_o | output | 1 | Drive flag for port B |
| le_ab_i | input | 1 | A-to-B latch enable, high = transparent |
| clk_ab_i | input | 1 | A-to-B capture clock, rise detected on clk_i |
| oe_ab_i | input | 1 | A-to-B output enable, active high |
| le_ba_i | input | 1 | B-to-A latch enable, high = transparent |
| clk_ba_i | input | 1 | B-to-A capture clock, rise detected on clk_i |
| oe_ba_ni | input | 1 | B-to-A output enable, active low |

## Verification
The bench builds the block with its default width of 18. The B-to-A path always uses the active-low enable variant, so both polarity branches of the output gate are elaborated and driven. Random 18-bit words reach every generated bit cell, and random control sequences mix latch-enable edges with direction-clock edges in every order. Directed sequences cover the cases that random traffic rarely hits: a latch-enable fall while the clock is still, a clock rise during transparency, and simultaneous drive on both ports.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned XCVR_W = 18;

  typedef struct packed {
    logic latch_en;
    logic dir_clk;
    logic oe_raw;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R5: a rise is a single-cycle event
  a_r5_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_bit_cell.sv
module xcvr_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic latch_en_i,
  input  logic cap_i,
  output logic q_o,
  output logic val_o
);
  logic q;

  // tracking while transparent makes an LE fall freeze the last seen value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= 1'b0;
    else if (latch_en_i | cap_i) q <= din_i;
  end

  assign q_o   = q;
  assign val_o = latch_en_i ? din_i : q;
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH         = XCVR_W,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  dir_ctl_t         ctl_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             drive_o
);
  logic             cap;
  logic             drive_en;
  logic [WIDTH-1:0] q_vec;
  logic [WIDTH-1:0] val_vec;

  xcvr_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctl_i.dir_clk),
    .rise_o (cap)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    xcvr_bit_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .din_i      (din_i[i]),
      .latch_en_i (ctl_i.latch_en),
      .cap_i      (cap & ~ctl_i.latch_en),
      .q_o        (q_vec[i]),
      .val_o      (val_vec[i])
    );
  end

  if (OE_ACTIVE_LOW) begin : g_oe_low
    assign drive_en = ~ctl_i.oe_raw;
  end else begin : g_oe_high
    assign drive_en = ctl_i.oe_raw;
  end

  assign drive_o = drive_en;
  assign dout_o  = drive_en ? val_vec : '0;

  a_r3_le_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.latch_en |=> q_vec == $past(din_i));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.latch_en && $stable(ctl_i.dir_clk)) |=> $stable(q_vec));
  a_r5_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.latch_en && ctl_i.dir_clk && !$past(ctl_i.dir_clk)) |=> q_vec == $past(din_i));
  a_r9_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> q_vec == '0);
endmodule

// File: rtl/xcvr_reg_bidir.sv
module xcvr_reg_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = XCVR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o,
  input  logic             le_ab_i,
  input  logic             clk_ab_i,
  input  logic             oe_ab_i,
  input  logic             le_ba_i,
  input  logic             clk_ba_i,
  input  logic             oe_ba_ni
);
  dir_ctl_t ctl_ab, ctl_ba;

  assign ctl_ab = '{latch_en: le_ab_i, dir_clk: clk_ab_i, oe_raw: oe_ab_i};
  assign ctl_ba = '{latch_en: le_ba_i, dir_clk: clk_ba_i, oe_raw: oe_ba_ni};

  xcvr_dir #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (a_i),
    .ctl_i   (ctl_ab),
    .dout_o  (b_o),
    .drive_o (b_oe_o)
  );

  xcvr_dir #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (b_i),
    .ctl_i   (ctl_ba),
    .dout_o  (a_o),
    .drive_o (a_oe_o)
  );

  a_r7_b_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_oe_o |-> b_o == '0);
  a_r8_a_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_oe_o |-> a_o == '0);
  a_r8_a_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_o == !oe_ba_ni);
  a_r2_b_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_ab_i && oe_ab_i) |-> b_o == a_i);
endmodule

// File: tb/tb_xcvr_reg_bidir.sv
`timescale 1ns/1ps
module tb_xcvr_reg_bidir;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe;
  logic le_ab = 0, ck_ab = 0, oe_ab = 0, le_ba = 0, ck_ba = 0, oe_ba_n = 1;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_q_ab = '0, m_q_ba = '0;
  logic m_prev_ab = 0, m_prev_ba = 0;

  always #4 clk = ~clk;

  xcvr_reg_bidir #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe),
    .le_ab_i(le_ab), .clk_ab_i(ck_ab), .oe_ab_i(oe_ab),
    .le_ba_i(le_ba), .clk_ba_i(ck_ba), .oe_ba_ni(oe_ba_n)
  );

  function automatic logic [W-1:0] exp_data(logic en, logic le, logic [W-1:0] din, logic [W-1:0] q);
    if (!en) return '0;
    return le ? din : q;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [W-1:0] a, logic [W-1:0] b, logic lab, logic cab, logic oab,
                     logic lba, logic cba, logic obn, string tag);
    @(negedge clk);
    a_in = a; b_in = b; le_ab = lab; ck_ab = cab; oe_ab = oab;
    le_ba = lba; ck_ba = cba; oe_ba_n = obn;
    @(posedge clk);
    if (!rst_n) begin
      m_q_ab = '0; m_q_ba = '0; m_prev_ab = 0; m_prev_ba = 0;
    end else begin
      if (lab || (cab && !m_prev_ab)) m_q_ab = a;
      if (lba || (cba && !m_prev_ba)) m_q_ba = b;
      m_prev_ab = cab; m_prev_ba = cba;
    end
    #1;
    chk({tag, " b_o"}, b_out, exp_data(oab, lab, a, m_q_ab));
    chk({tag, " a_o"}, a_out, exp_data(!obn, lba, b, m_q_ba));
    chk({tag, " b_oe_o"}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, oab});
    chk({tag, " a_oe_o"}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, !obn});
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1d));
    // R9 reset state with both ports enabled
    cyc(18'h3ffff, 18'h2aaaa, 0, 0, 1, 0, 0, 0, "R9 reset");
    cyc(18'h15555, 18'h0f0f0, 0, 1, 1, 0, 1, 0, "R9 reset clk");
    @(negedge clk); ck_ab = 0; ck_ba = 0; rst_n = 1;
    cyc(18'h12345, 18'h0, 0, 0, 1, 0, 0, 0, "R9 after reset");
    // R2 transparent
    cyc(18'h11111, 18'h0, 1, 0, 1, 0, 0, 1, "R2 transparent");
    cyc(18'h22222, 18'h0, 1, 0, 1, 0, 0, 1, "R2 transparent follow");
    // R3 latch-enable fall with still clock
    cyc(18'h33333, 18'h0, 0, 0, 1, 0, 0, 1, "R3 le fall");
    // R4 hold with clock held low and high
    cyc(18'h03c3c, 18'h0, 0, 0, 1, 0, 0, 1, "R4 hold low");
    // R5 capture on rise
    cyc(18'h24680, 18'h0, 0, 1, 1, 0, 0, 1, "R5 capture");
    cyc(18'h13579, 18'h0, 0, 1, 1, 0, 0, 1, "R4 hold high");
    cyc(18'h3abcd, 18'h0, 0, 0, 1, 0, 0, 1, "R4 hold fall");
    // R6 clock rise during transparency
    cyc(18'h00aaa, 18'h0, 1, 1, 1, 0, 0, 1, "R6 rise while le");
    cyc(18'h01bbb, 18'h0, 1, 1, 1, 0, 0, 1, "R6 transparent");
    cyc(18'h02ccc, 18'h0, 0, 1, 1, 0, 0, 1, "R3 le fall clk high");
    // R7 output disable
    cyc(18'h3ffff, 18'h0, 1, 0, 0, 0, 0, 1, "R7 b disabled");
    // R8 B-to-A modes
    cyc(18'h0, 18'h1f00f, 0, 0, 0, 1, 0, 0, "R8 transparent");
    cyc(18'h0, 18'h2e0e0, 0, 0, 0, 0, 0, 0, "R8 le fall");
    cyc(18'h0, 18'h3d0d0, 0, 0, 0, 0, 1, 0, "R8 capture");
    cyc(18'h0, 18'h0c0c0, 0, 0, 0, 0, 1, 0, "R8 hold");
    cyc(18'h0, 18'h3ffff, 0, 0, 0, 1, 0, 1, "R8 a disabled");
    // R10 both ports driving, R1 independence
    cyc(18'h2a5a5, 18'h15a5a, 1, 0, 1, 1, 0, 0, "R10 both drive");
    cyc(18'h00001, 18'h20000, 0, 1, 1, 0, 0, 0, "R1 ab capture ba hold");
    for (int k = 0; k < 4000; k++) begin
      cyc(W'($urandom), W'($urandom),
          ($urandom % 4) == 0, $urandom % 2, ($urandom % 5) != 0,
          ($urandom % 4) == 0, $urandom % 2, ($urandom % 5) == 0,
          "R1 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule